// File: doc/BRIEF.md
# Chainable Dual 16-bit Timer/Counter

This block holds two 16-bit count units, half A and half B. Each half counts module-clock ticks or qualified events on its own external input. The count runs up or down. When it runs past its limit it reloads, and it then either keeps running or stops. A control bit in half A joins the two halves into one 32-bit unit. In that mode A supplies the low half and B the high half, and the joined unit reports its wrap only through A's interrupt bit.

Software drives the block through a plain register port. A write takes one clock. A read is combinational from the read address. Each half has four registers:

- a configuration word;
- a write-only command word that starts, stops or reloads the count;
- a reload value;
- a read-only count.

Two shared registers handle interrupts. One is an interrupt mask. The other reads back the pending bits, and writing ones to it clears the matching bits.

Top module: `tc_pair`

## Requirements
- R1: After reset every register reads 0, no half is enabled, and both irq outputs are low.
- R2: An enabled half in plain timer mode moves its count by one every clock. Configuration bit2=0 and bit9=0 select plain timer mode. Bit1=1 makes the count go up and bit1=0 makes it go down.
- R3: The command word for half A is at 0x18 and for half B at 0x1C. Writing bit2 copies the reload value into the count. Bit0 sets the enable, and bit1 clears it (clear wins). A write of bit0 alone resumes from the held count. Configuration bit0 reads the enable, and a disabled half holds its count.
- R4: A half wraps when it steps down from 0, or steps up from 0xFFFF. On a wrap the count takes the reload value and the half's pending bit is set. With configuration bit3=0 the half keeps running.
- R5: With configuration bit3=1, a wrap also clears the half's enable.
- R6: Bit2=1 with bit10=0 selects event mode. In event mode the half steps on events qualified by bits 7:6. Value 0 steps on each clock while the input is high. Value 1 steps on a rising edge, value 2 on a falling edge, and value 3 on either edge. An edge is the current sample compared with the sample one clock earlier.
- R7: Configuration bit5 inverts the external input before qualification, so level mode then steps while the input is low.
- R8: Configuration bit8 routes the input through a two-stage synchroniser. A level step then lands two clocks later than it does with bit8=0.
- R9: Bit4 of half A's configuration joins the halves. A holds the low 16 bits and B the high 16 bits. B steps on A's carry or borrow. The command word of A governs the whole unit. A 32-bit wrap reloads both halves and sets only pending bit 0. B's configuration bit4 always reads 0.
- R10: Pending bit 0 belongs to A and bit 1 to B. Reading 0xFC returns the pending bits, and writing ones to 0xFC clears them. A wrap in the same clock as a clear leaves the bit set. The mask at 0xF4 uses the same bit layout, and irq equals pending AND mask.
- R11: Source select. In event mode with bit10=1 the half counts clock ticks. In timer mode with bit9=1 it counts qualified events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| ext_in | input | 2 | External event inputs, bit 0 for half A and bit 1 for half B |
| irq | output | 2 | Masked interrupt requests, bit 0 for A and bit 1 for B |

## Verification
Two situations are hard to reach from the ports. The first is a wrap that falls in the same clock as a write to the clear register. The bench loads a reload value two steps below the top of the range, so that it knows the exact wrap cycle, and then issues the clear write so that it completes on that edge. The second is a 32-bit wrap or borrow in joined mode. Reaching it by counting from an arbitrary value would take tens of thousands of clocks. The bench instead loads reload values one step away from a carry or borrow, so that a boundary falls within one or two clocks. Random event streams cover every qualification and inversion setting on both halves.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int unsigned ADDR_W = 8;

    typedef enum logic [1:0] {
        QUAL_LEVEL = 2'd0,
        QUAL_RISE  = 2'd1,
        QUAL_FALL  = 2'd2,
        QUAL_BOTH  = 2'd3
    } qual_e;

    // Configuration bits 10:1, with the MSB first
    typedef struct packed {
        logic  src_sel_n;  // bit10: 0 picks events in event mode
        logic  ext_tmr;    // bit9 : timer mode counts events
        logic  sync;       // bit8 : synchronise input
        qual_e qual;       // bits7:6
        logic  inv;        // bit5
        logic  chain;      // bit4 (half A only)
        logic  one_shot;   // bit3
        logic  evt_mode;   // bit2
        logic  up;         // bit1
    } ctrl_t;

    localparam int unsigned CFG_LSB = 1;
    localparam int unsigned CFG_MSB = 10;

    localparam int unsigned CMD_SET  = 0;
    localparam int unsigned CMD_CLR  = 1;
    localparam int unsigned CMD_LOAD = 2;

    localparam logic [ADDR_W-1:0] ADR_CFG_A = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_CFG_B = 8'h14;
    localparam logic [ADDR_W-1:0] ADR_CMD_A = 8'h18;
    localparam logic [ADDR_W-1:0] ADR_CMD_B = 8'h1C;
    localparam logic [ADDR_W-1:0] ADR_RLD_A = 8'h20;
    localparam logic [ADDR_W-1:0] ADR_RLD_B = 8'h24;
    localparam logic [ADDR_W-1:0] ADR_CNT_A = 8'h28;
    localparam logic [ADDR_W-1:0] ADR_CNT_B = 8'h2C;
    localparam logic [ADDR_W-1:0] ADR_MASK  = 8'hF4;
    localparam logic [ADDR_W-1:0] ADR_PEND  = 8'hFC;

endpackage

// File: rtl/tc_event_qual.sv
module tc_event_qual #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_i,
    input  logic          sync_en_i,
    input  logic          invert_i,
    input  tc_pkg::qual_e qual_i,
    output logic          event_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } eq_state_t;

    eq_state_t q, d;
    logic      sample;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], raw_i};
        sample = (sync_en_i ? q.sync[SYNC_STAGES-1] : raw_i) ^ invert_i;
        d.prev = sample;
        unique case (qual_i)
            tc_pkg::QUAL_LEVEL: event_o = sample;
            tc_pkg::QUAL_RISE:  event_o = sample & ~q.prev;
            tc_pkg::QUAL_FALL:  event_o = ~sample & q.prev;
            tc_pkg::QUAL_BOTH:  event_o = sample ^ q.prev;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tc_step.sv
module tc_step #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cnt_i,
    input  logic         up_i,
    output logic [W-1:0] nxt_o,
    output logic         limit_o
);
    always_comb begin
        nxt_o   = up_i ? cnt_i + W'(1) : cnt_i - W'(1);
        limit_o = up_i ? (&cnt_i) : ~(|cnt_i);
    end
endmodule

// File: rtl/tc_pair.sv
module tc_pair #(
    parameter int unsigned HALF_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [tc_pkg::ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0]         wr_data,
    input  logic [tc_pkg::ADDR_W-1:0] rd_addr,
    output logic [HALF_W-1:0]         rd_data,
    input  logic [1:0]                ext_in,
    output logic [1:0]                irq
);
    import tc_pkg::*;

    localparam int unsigned NHALF = 2;
    localparam int unsigned CFG_W = CFG_MSB - CFG_LSB + 1;

    typedef struct packed {
        ctrl_t [NHALF-1:0]             ctrl;
        logic  [NHALF-1:0]             en;
        logic  [NHALF-1:0][HALF_W-1:0] rld;
        logic  [NHALF-1:0][HALF_W-1:0] cnt;
        logic  [NHALF-1:0]             pend;
        logic  [NHALF-1:0]             mask;
    } state_t;

    state_t            q, d;
    logic              chain_on;
    logic [NHALF-1:0]  evt_v, step_v, lim_v, up_v;
    logic [HALF_W-1:0] nxt_v [NHALF];

    assign chain_on = q.ctrl[0].chain;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic use_evt;

        tc_event_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_i     (ext_in[h]),
            .sync_en_i (q.ctrl[h].sync),
            .invert_i  (q.ctrl[h].inv),
            .qual_i    (q.ctrl[h].qual),
            .event_o   (evt_v[h])
        );

        assign use_evt   = q.ctrl[h].evt_mode ? ~q.ctrl[h].src_sel_n : q.ctrl[h].ext_tmr;
        assign step_v[h] = use_evt ? evt_v[h] : 1'b1;

        if (h == 0) begin : g_dir_a
            assign up_v[h] = q.ctrl[0].up;
        end else begin : g_dir_b
            assign up_v[h] = chain_on ? q.ctrl[0].up : q.ctrl[h].up;
        end

        tc_step #(.W(HALF_W)) u_step (
            .cnt_i   (q.cnt[h]),
            .up_i    (up_v[h]),
            .nxt_o   (nxt_v[h]),
            .limit_o (lim_v[h])
        );
    end

    // next-state computation
    logic [NHALF-1:0] pset, pclr;
    logic             cmd_hit;
    logic             cmd_h;

    always_comb begin
        d    = q;
        pset = '0;

        if (!chain_on) begin
            for (int h = 0; h < NHALF; h++) begin
                if (q.en[h] && step_v[h]) begin
                    if (lim_v[h]) begin
                        d.cnt[h] = q.rld[h];
                        pset[h]  = 1'b1;
                        if (q.ctrl[h].one_shot) d.en[h] = 1'b0;
                    end else begin
                        d.cnt[h] = nxt_v[h];
                    end
                end
            end
        end else if (q.en[0] && step_v[0]) begin
            if (lim_v[0] && lim_v[1]) begin
                d.cnt[0] = q.rld[0];
                d.cnt[1] = q.rld[1];
                pset[0]  = 1'b1;
                if (q.ctrl[0].one_shot) d.en[0] = 1'b0;
            end else begin
                d.cnt[0] = nxt_v[0];
                if (lim_v[0]) d.cnt[1] = nxt_v[1];
            end
        end

        cmd_hit = 1'b0;
        cmd_h   = 1'b0;
        pclr    = '0;
        if (wr_en) begin
            case (wr_addr)
                ADR_CFG_A: d.ctrl[0] = ctrl_t'(wr_data[CFG_MSB:CFG_LSB]);
                ADR_CFG_B: begin
                    d.ctrl[1]       = ctrl_t'(wr_data[CFG_MSB:CFG_LSB]);
                    d.ctrl[1].chain = 1'b0;
                end
                ADR_CMD_A: cmd_hit = 1'b1;
                ADR_CMD_B: begin
                    cmd_hit = ~chain_on;
                    cmd_h   = 1'b1;
                end
                ADR_RLD_A: d.rld[0] = wr_data;
                ADR_RLD_B: d.rld[1] = wr_data;
                ADR_MASK:  d.mask   = wr_data[NHALF-1:0];
                ADR_PEND:  pclr     = wr_data[NHALF-1:0];
                default: ;
            endcase
        end

        if (cmd_hit) begin
            if (wr_data[CMD_LOAD]) begin
                d.cnt[cmd_h] = q.rld[cmd_h];
                if (chain_on) d.cnt[1] = q.rld[1];
            end
            if (wr_data[CMD_SET]) d.en[cmd_h] = 1'b1;
            if (wr_data[CMD_CLR]) d.en[cmd_h] = 1'b0;
        end

        d.pend = (q.pend & ~pclr) | pset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (rd_addr)
            ADR_CFG_A: rd_data = HALF_W'({q.ctrl[0], q.en[0]});
            ADR_CFG_B: rd_data = HALF_W'({q.ctrl[1], q.en[1]});
            ADR_RLD_A: rd_data = q.rld[0];
            ADR_RLD_B: rd_data = q.rld[1];
            ADR_CNT_A: rd_data = q.cnt[0];
            ADR_CNT_B: rd_data = q.cnt[1];
            ADR_MASK:  rd_data = HALF_W'(q.mask);
            ADR_PEND:  rd_data = HALF_W'(q.pend);
            default:   rd_data = '0;
        endcase
    end

    assign irq = q.pend & q.mask;

    // observation nets for the bound checker
    logic [NHALF-1:0]  en_vec, pend_vec;
    logic [HALF_W-1:0] cnt_b_vec;
    logic              oneshot_a;
    assign en_vec    = q.en;
    assign pend_vec  = q.pend;
    assign cnt_b_vec = q.cnt[1];
    assign oneshot_a = q.ctrl[0].one_shot;

    if (CFG_W != $bits(ctrl_t)) begin : g_bad_cfg
        initial $display("configuration width mismatch");
    end
endmodule

// File: rtl/tc_pair_chk.sv
module tc_pair_chk #(
    parameter int unsigned HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        en,
    input logic [1:0]        pend,
    input logic [HALF_W-1:0] cnt_b,
    input logic              chain,
    input logic              oneshot_a
);
    AST_PEND_A_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[0]) |-> $past(en[0])) else $display("assertion fail R4");  // R4

    AST_B_QUIET_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[1]) |-> $past(en[1] && !chain)) else $display("assertion fail R9");  // R9

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pend[0]) && $past(oneshot_a) && !$past(wr_en)) |-> !en[0]) else $display("assertion fail R5");  // R5

    AST_EN_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en[0]) |-> ($past(wr_en) || $past(oneshot_a))) else $display("assertion fail R3");  // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !en[1] && !chain) |=> $stable(cnt_b)) else $display("assertion fail R3");  // R3
endmodule

bind tc_pair tc_pair_chk #(.HALF_W(HALF_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .en        (en_vec),
    .pend      (pend_vec),
    .cnt_b     (cnt_b_vec),
    .chain     (chain_on),
    .oneshot_a (oneshot_a)
);

// File: tb/tc_pair_tb_top.sv
`timescale 1ns/1ps
module tc_pair_tb_top;
    localparam logic [7:0] CFG_A = 8'h10, CFG_B = 8'h14, CMD_A = 8'h18, CMD_B = 8'h1C;
    localparam logic [7:0] RLD_A = 8'h20, RLD_B = 8'h24, CNT_A = 8'h28, CNT_B = 8'h2C;
    localparam logic [7:0] MASK = 8'hF4, PEND = 8'hFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  ext_in = '0;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tc_pair dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_in(ext_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [15:0] exp);
        rd_addr = a;
        #0.5;
        chk(req, 32'(rd_data), 32'(exp));
    endtask

    function automatic bit evt_model(input int qual, input bit s, input bit prev);
        case (qual)
            0: return s;
            1: return s && !prev;
            2: return !s && prev;
            default: return s != prev;
        endcase
    endfunction

    task automatic evt_trial(input int h, input int qual, input bit inv, input bit up);
        bit   prev = 1'b0;
        int   n = 0;
        logic [15:0] exp;
        ext_in[h] = inv;
        wr(h ? CFG_B : CFG_A, 16'h0004 | 16'(qual << 6) | 16'(inv << 5) | 16'(up << 1));
        wr(h ? RLD_B : RLD_A, 16'h8000);
        wr(h ? CMD_B : CMD_A, 16'h0005);
        for (int k = 0; k < 25; k++) begin
            bit b, s;
            b = (k == 24) ? inv : 1'($urandom_range(0, 1));
            ext_in[h] = b;
            s = b ^ inv;
            if (evt_model(qual, s, prev)) n++;
            prev = s;
            @(negedge clk);
        end
        exp = up ? 16'h8000 + 16'(n) : 16'h8000 - 16'(n);
        chk_reg(inv ? "R6 R7 inverted event count" : "R6 event count", h ? CNT_B : CNT_A, exp);
        wr(h ? CMD_B : CMD_A, 16'h0002);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        ticks(3);
        rst_n = 1'b1;
        ticks(1);
        // R1 reset state
        chk_reg("R1 cfg A", CFG_A, 16'h0);
        chk_reg("R1 count A", CNT_A, 16'h0);
        chk_reg("R1 reload B", RLD_B, 16'h0);
        chk_reg("R1 pending", PEND, 16'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 / R3 timer down, stop, resume
        wr(RLD_A, 16'd100);
        wr(CFG_A, 16'h0000);
        wr(CMD_A, 16'h0005);
        chk_reg("R3 load", CNT_A, 16'd100);
        chk_reg("R3 enable status", CFG_A, 16'h0001);
        ticks(7);
        chk_reg("R2 count down", CNT_A, 16'd93);
        wr(CMD_A, 16'h0002);
        ticks(5);
        chk_reg("R3 stop holds", CNT_A, 16'd92);
        chk_reg("R3 enable cleared", CFG_A, 16'h0000);
        wr(CMD_A, 16'h0001);
        chk_reg("R3 resume keeps count", CNT_A, 16'd92);
        ticks(4);
        chk_reg("R3 resume runs", CNT_A, 16'd88);
        wr(CMD_A, 16'h0002);

        // R4 / R10 cyclic up wrap, interrupt, clear, set-wins
        wr(RLD_A, 16'hFFFD);
        wr(CFG_A, 16'h0002);
        wr(MASK, 16'h0001);
        wr(CMD_A, 16'h0005);
        ticks(3);
        chk_reg("R4 wrap reload", CNT_A, 16'hFFFD);
        chk_reg("R10 pending A", PEND, 16'h0001);
        chk("R10 irq A", 32'(irq), 32'h1);
        ticks(1);
        chk_reg("R4 cyclic continues", CNT_A, 16'hFFFE);
        wr(PEND, 16'h0001);
        chk_reg("R10 clear", PEND, 16'h0000);
        chk("R10 irq low", 32'(irq), 32'h0);
        wr(PEND, 16'h0001);
        chk_reg("R10 set wins over clear", PEND, 16'h0001);
        chk_reg("R4 second wrap", CNT_A, 16'hFFFD);

        // R5 one-shot
        wr(CMD_A, 16'h0002);
        wr(PEND, 16'h0003);
        wr(RLD_A, 16'd3);
        wr(CFG_A, 16'h0008);
        wr(CMD_A, 16'h0005);
        ticks(6);
        chk_reg("R5 one-shot count", CNT_A, 16'd3);
        chk_reg("R5 enable off", CFG_A, 16'h0008);
        chk_reg("R5 pending", PEND, 16'h0001);
        wr(MASK, 16'h0000);
        chk("R10 masked irq", 32'(irq), 32'h0);
        chk_reg("R10 mask keeps pending", PEND, 16'h0001);
        wr(PEND, 16'h0001);

        // R6 / R7 random event streams
        for (int t = 0; t < 16; t++) begin
            evt_trial(int'($urandom_range(0, 1)), t % 4, 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)));
        end
        ext_in = '0;

        // R8 synchroniser latency
        wr(CFG_A, 16'h0106);
        wr(RLD_A, 16'd10);
        wr(CMD_A, 16'h0005);
        ext_in[0] = 1'b1;
        ticks(2);
        chk_reg("R8 sync delay", CNT_A, 16'd10);
        ticks(1);
        chk_reg("R8 sync step", CNT_A, 16'd11);
        ext_in[0] = 1'b0;
        wr(CMD_A, 16'h0002);
        ticks(3);

        // R11 source select
        wr(CFG_A, 16'h0406);
        wr(RLD_A, 16'd20);
        wr(CMD_A, 16'h0005);
        ticks(5);
        chk_reg("R11 event mode ticks", CNT_A, 16'd25);
        wr(CMD_A, 16'h0002);
        wr(CFG_A, 16'h0202);
        wr(RLD_A, 16'd20);
        wr(CMD_A, 16'h0005);
        ticks(5);
        chk_reg("R11 timer waits for events", CNT_A, 16'd20);
        ext_in[0] = 1'b1;
        ticks(3);
        ext_in[0] = 1'b0;
        ticks(2);
        chk_reg("R11 timer counts events", CNT_A, 16'd23);
        wr(CMD_A, 16'h0002);

        // R9 chained 32-bit
        wr(CFG_B, 16'h0010);
        chk_reg("R9 B chain bit reads 0", CFG_B, 16'h0000);
        wr(CFG_A, 16'h0010);
        wr(RLD_A, 16'h0000);
        wr(RLD_B, 16'h0001);
        wr(PEND, 16'h0003);
        wr(MASK, 16'h0003);
        wr(CMD_A, 16'h0005);
        ticks(1);
        chk_reg("R9 borrow low", CNT_A, 16'hFFFF);
        chk_reg("R9 borrow high", CNT_B, 16'h0000);
        chk_reg("R9 cfg A readback", CFG_A, 16'h0011);
        wr(CMD_A, 16'h0002);
        wr(RLD_A, 16'h0001);
        wr(RLD_B, 16'h0000);
        wr(CMD_A, 16'h0005);
        ticks(2);
        chk_reg("R9 32-bit wrap low", CNT_A, 16'h0001);
        chk_reg("R9 32-bit wrap high", CNT_B, 16'h0000);
        chk_reg("R9 only A pending", PEND, 16'h0001);
        chk("R9 irq", 32'(irq), 32'h1);
        wr(CMD_A, 16'h0002);
        wr(PEND, 16'h0003);
        wr(RLD_A, 16'hFFFF);
        wr(CFG_A, 16'h0012);
        wr(CMD_A, 16'h0005);
        ticks(1);
        chk_reg("R9 carry low", CNT_A, 16'h0000);
        chk_reg("R9 carry high", CNT_B, 16'h0001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule